// File: doc/BRIEF.md
# Floating-Point Status Word and Exception Accumulator

This block owns the 32-bit floating-point status word. It decodes two controls from that word for an arithmetic datapath that sits outside it: the rounding mode and a single flush-to-zero control. That one control covers both denormal operands and denormal results.

After each arithmetic operation the datapath presents a strobe and five raw exception indications. The block ORs those indications into sticky flag bits and raises a trap request in the same cycle when any reported exception has its enable bit set. The flag field sits at a fixed distance above the enable field, so the flag update is a shifted OR of the exception vector. The trap test is an AND of the exceptions against the enables.

Software can replace the whole word through a write port, and a write wins over an operation update in the same cycle.

Top module: `fpsw_accum`

## Requirements
- R1: After a synchronous active-high reset, `status_word` is 0. This means round to nearest even (`round_mode` = 0), both flush outputs low and `trap_req` low.
- R2: `round_mode` reflects word bits 10:9 with the encoding 0 = nearest even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity.
- R3: Word bit 5 drives `flush_denorm_in` and `flush_denorm_out` together.
- R4: When `sw_we` is high at a clock edge, `status_word` equals `sw_wdata` after that edge.
- R5: `op_exc` bit positions are 0 = inexact, 1 = underflow, 2 = overflow, 3 = divide-by-zero and 4 = invalid. Enables sit at word bits 4:0 in the same order. When `op_valid` is high and `sw_we` is low, each set `op_exc[k]` sets word bit 27+k at the next edge.
- R6: Flags are sticky: no operation clears a flag bit. An operation changes no bits other than the flags.
- R7: An operation that reports no exceptions leaves the word unchanged. `op_exc` is ignored while `op_valid` is low.
- R8: `trap_req` is high in the cycle of the `op_valid` strobe exactly when `op_exc & word[4:0]` is non-zero. It is low in every other case.
- R9: A write and an operation in the same cycle load `sw_wdata`; the operation's flags are discarded.
- R10: In a cycle with both a write and an operation, the trap test uses the enables held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Word loaded on a software write |
| op_valid | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Raw exceptions of that operation (bit 0 inexact … bit 4 invalid) |
| status_word | output | 32 | Current status word |
| round_mode | output | 2 | Decoded rounding mode |
| flush_denorm_in | output | 1 | Flush denormal operands to zero |
| flush_denorm_out | output | 1 | Flush denormal results to zero |
| trap_req | output | 1 | Same-cycle trap request for an enabled exception |

## Verification
The assertions assume that `op_exc` carries meaning only while `op_valid` is high, and that every input is stable around the clock edge. The stimulus drives all inputs on the falling edge. In some idle cycles it deliberately leaves `op_exc` non-zero with the strobe low, to show those bits are ignored. The temporal checks start only after one full cycle out of reset, so that the cycle before reset release is never compared.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;

    localparam int WORD_W    = 32;
    localparam int EXC_N     = 5;
    localparam int ENA_LSB   = 0;
    localparam int FLG_LSB   = 27;
    localparam int RM_LSB    = 9;
    localparam int RM_W      = 2;
    localparam int FLUSH_POS = 5;

    typedef enum logic [RM_W-1:0] {
        RND_NEAREST_EVEN = 2'd0,
        RND_TOWARD_ZERO  = 2'd1,
        RND_TOWARD_POS   = 2'd2,
        RND_TOWARD_NEG   = 2'd3
    } rnd_mode_e;

    // bit 0 inexact ... bit 4 invalid
    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_vec_t;

    function automatic rnd_mode_e decode_rm(input logic [RM_W-1:0] fld);
        rnd_mode_e m;
        case (fld)
            2'd1:    m = RND_TOWARD_ZERO;
            2'd2:    m = RND_TOWARD_POS;
            2'd3:    m = RND_TOWARD_NEG;
            default: m = RND_NEAREST_EVEN;
        endcase
        return m;
    endfunction

    function automatic logic any_exc(input exc_vec_t e);
        return |e;
    endfunction

endpackage

// File: rtl/fpsw_decode.sv
module fpsw_decode
    import fpsw_pkg::*;
(
    input  logic [RM_W-1:0] rm_field,
    input  logic            flush_bit,
    output rnd_mode_e       rm,
    output logic            flush_in,
    output logic            flush_out
);
    always_comb begin
        rm        = decode_rm(rm_field);
        flush_in  = flush_bit;
        flush_out = flush_bit;
    end
endmodule

// File: rtl/fpsw_trap.sv
module fpsw_trap
    import fpsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_valid,
    input  exc_vec_t exc,
    input  exc_vec_t enables,
    output logic     trap
);
    exc_vec_t hit;

    always_comb begin
        hit  = exc & enables;
        trap = op_valid && any_exc(hit);
    end

    AST_TRAP_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        trap |-> op_valid);  // R8
endmodule

// File: rtl/fpsw_reg.sv
module fpsw_reg
    import fpsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              op_valid,
    input  exc_vec_t          exc,
    output logic [WORD_W-1:0] word
);
    localparam int FLG_MSB = FLG_LSB + EXC_N - 1;

    logic [EXC_N-1:0]  exc_bits;
    logic [EXC_N-1:0]  flag_next;
    logic [WORD_W-1:0] op_word;
    logic              past_ok;

    assign exc_bits = exc;

    genvar k;
    generate
        for (k = 0; k < EXC_N; k++) begin : g_flag
            assign flag_next[k] = word[FLG_LSB+k] | (op_valid & exc_bits[k]);
        end
    endgenerate

    always_comb begin
        op_word                  = word;
        op_word[FLG_MSB:FLG_LSB] = flag_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word    <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (we)
                word <= wdata;
            else if (op_valid && any_exc(exc))
                word <= op_word;
        end
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(we) |-> word == $past(wdata));  // R4
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(we) |->
            (word[FLG_MSB:FLG_LSB] & $past(word[FLG_MSB:FLG_LSB])) == $past(word[FLG_MSB:FLG_LSB]));  // R6
    AST_OP_TOUCHES_FLAGS_ONLY: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(we) |-> word[FLG_LSB-1:0] == $past(word[FLG_LSB-1:0]));  // R6
    AST_FLAGS_SET: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(we) && $past(op_valid) |->
            (word[FLG_MSB:FLG_LSB] & $past(exc_bits)) == $past(exc_bits));  // R5
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(we) && !($past(op_valid) && ($past(exc_bits) != '0)) |-> $stable(word));  // R7
endmodule

// File: rtl/fpsw_accum.sv
module fpsw_accum
    import fpsw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_we,
    input  logic [31:0] sw_wdata,
    input  logic        op_valid,
    input  logic [4:0]  op_exc,
    output logic [31:0] status_word,
    output logic [1:0]  round_mode,
    output logic        flush_denorm_in,
    output logic        flush_denorm_out,
    output logic        trap_req
);
    logic [WORD_W-1:0] word;
    exc_vec_t          exc;
    exc_vec_t          enables;
    rnd_mode_e         rm;

    assign exc     = exc_vec_t'(op_exc);
    assign enables = exc_vec_t'(word[ENA_LSB +: EXC_N]);

    fpsw_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .we       (sw_we),
        .wdata    (sw_wdata),
        .op_valid (op_valid),
        .exc      (exc),
        .word     (word)
    );

    fpsw_decode u_dec (
        .rm_field  (word[RM_LSB +: RM_W]),
        .flush_bit (word[FLUSH_POS]),
        .rm        (rm),
        .flush_in  (flush_denorm_in),
        .flush_out (flush_denorm_out)
    );

    fpsw_trap u_trap (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .exc      (exc),
        .enables  (enables),
        .trap     (trap_req)
    );

    assign status_word = word;
    assign round_mode  = rm;
endmodule

// File: tb/tb_fpsw_accum.sv
module tb_fpsw_accum;

    typedef struct {
        logic        trap;
        logic [31:0] word;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_exc = '0;
    logic [31:0] status_word;
    logic [1:0]  round_mode;
    logic        flush_denorm_in;
    logic        flush_denorm_out;
    logic        trap_req;

    int          errors = 0;
    int          checks = 0;
    logic [31:0] model = '0;
    exp_t        sb[$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fpsw_accum dut (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .op_valid(op_valid), .op_exc(op_exc), .status_word(status_word),
        .round_mode(round_mode), .flush_denorm_in(flush_denorm_in),
        .flush_denorm_out(flush_denorm_out), .trap_req(trap_req)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected outcome pushed to the scoreboard
    task automatic step(logic we, logic [31:0] wd, logic ov, logic [4:0] ex, string tag);
        exp_t it;
        @(negedge clk);
        sw_we = we; sw_wdata = wd; op_valid = ov; op_exc = ex;
        it.trap = ov && ((ex & model[4:0]) != 5'd0);
        if (we) model = wd;
        else if (ov) model = model | ({27'd0, ex} << 27);
        it.word = model;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    // monitor: trap before the edge, state after it
    initial begin
        forever begin
            exp_t it;
            @(negedge clk);
            #2;
            if (sb.size() != 0) begin
                it = sb.pop_front();
                check(it.tag, "trap_req", {31'd0, trap_req}, {31'd0, it.trap});
                @(posedge clk);
                #1;
                check(it.tag, "status_word", status_word, it.word);
                check({it.tag, "/R2"}, "round_mode", {30'd0, round_mode}, {30'd0, it.word[10:9]});
                check({it.tag, "/R3"}, "flush", {30'd0, flush_denorm_in, flush_denorm_out},
                      {30'd0, it.word[5], it.word[5]});
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        sw_we = 1'b1; sw_wdata = 32'hFFFF_FFFF; // must be overridden by reset
        @(negedge clk);
        rst = 1'b0; sw_we = 1'b0;
        #1;
        check("R1", "status_word", status_word, 32'h0);
        check("R1", "round_mode", {30'd0, round_mode}, 32'h0);
        check("R1", "flush", {30'd0, flush_denorm_in, flush_denorm_out}, 32'h0);
        check("R1", "trap_req", {31'd0, trap_req}, 32'h0);

        // R2 every rounding field value, R4 full-word load
        for (int m = 0; m < 4; m++)
            step(1'b1, 32'h0 | (m << 9), 1'b0, 5'd0, "R2");
        step(1'b1, 32'h5A5A_A5A5, 1'b0, 5'd0, "R4");
        // R3 flush bit on, then off
        step(1'b1, 32'h0000_0020, 1'b0, 5'd0, "R3");
        step(1'b1, 32'h0000_0400, 1'b0, 5'd0, "R3");
        // R5 each exception with enables off, accumulates
        for (int k = 0; k < 5; k++)
            step(1'b0, 32'h0, 1'b1, 5'd1 << k, "R5");
        // R6 repeat reporting does not clear anything
        step(1'b0, 32'h0, 1'b1, 5'b00100, "R6");
        // R7 no exceptions, and strobe low with exceptions present
        step(1'b0, 32'h0, 1'b1, 5'd0, "R7");
        step(1'b0, 32'h0, 1'b0, 5'h1F, "R7");
        // R8 enable inexact only
        step(1'b1, 32'h0000_0221, 1'b0, 5'd0, "R8");
        step(1'b0, 32'h0, 1'b1, 5'b00010, "R8");
        step(1'b0, 32'h0, 1'b0, 5'b00001, "R8");
        step(1'b0, 32'h0, 1'b1, 5'b00001, "R8");
        step(1'b0, 32'h0, 1'b1, 5'b10011, "R8");
        // R9 write beats a same-cycle operation
        step(1'b1, 32'h0000_001F, 1'b1, 5'h1F, "R9");
        // R10 trap uses enables held before the write
        step(1'b1, 32'h0, 1'b1, 5'b00100, "R10");
        step(1'b0, 32'h0, 1'b1, 5'b00100, "R10");
        step(1'b0, 32'h0, 1'b0, 5'd0, "R7");

        @(negedge clk);
        sw_we = 1'b0; op_valid = 1'b0; op_exc = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule